// File: doc/BRIEF.md
# Pausable Watchdog Timer with Reset Logging

This block is a register-mapped watchdog. Software writes a start value into a countdown of microseconds and then sets an enable bit. Each pulse on a one-microsecond tick input then lowers the count by one. The count stops while the enable bit is clear, and also while any armed pause source is active. There are three pause sources: a JTAG bus-access indicator and the debug state of two processors. When the count runs out, the block raises a one-cycle reset request and records the cause. Software can also raise the request at once by writing a trigger bit.

The reset request also acts as a soft reset for the watchdog itself. It clears the enable bit and the count. It keeps the pause arming bits, the cause register and eight 32-bit scratch words, so software can leave notes for itself across a soft reset. A debugger warm reset of either processor clears the recorded cause. The hardware reset `rst_ni` clears everything. Word accesses use byte addresses. Address bits 1:0 are ignored and reads are combinational.

Top module: `soft_watchdog`

## Requirements
- R1: After a hardware reset, every readable word reads 0 and `wdog_rst_o` and `reason_o` are 0.
- R2: A write to the load word (0x4) sets the count to wdata[CNT_W-1:0]. The control word (0x0) shows the count in bits CNT_W-1:0. The load word always reads 0.
- R3: The count drops by one on each cycle where `tick_i` is high, the enable bit (control bit 30) is set and no armed pause is active. In every other cycle it holds, and it never wraps below zero.
- R4: Control bits 24, 25 and 26 arm pausing on `jtag_busy_i`, `dbg0_i` and `dbg1_i` respectively. A source stops the count only while it is armed, and the arming bits read back from the same positions.
- R5: A running tick that finds the count at 1 or 0 leaves the count at 0. It raises `wdog_rst_o` for exactly one cycle, from the next clock edge, and sets the cause to 2'b01 (bit 0 means timer expiry, read at offset 0x8).
- R6: Writing control bit 31 as 1 raises `wdog_rst_o` for one cycle from that write's clock edge and sets the cause to 2'b10 (bit 1 means forced trigger). Control bit 31 always reads 0.
- R7: At the edge that raises a reset request, the enable bit and the count go to 0. The pause arming bits, the cause and the scratch words are kept.
- R8: A high on `warm_rst0_i` or `warm_rst1_i` clears the cause to 0 at the next edge, unless a reset request is raised at that edge.
- R9: Eight 32-bit read-write scratch words sit at 0x0C + 4*k for k = 0..7 and keep their contents through a watchdog reset request.
- R10: Offsets 0x2C to 0x3C, and all bits with no defined field, read 0. Writes to the cause word and to the count view in the control word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| tick_i | input | 1 | One-microsecond tick pulse |
| jtag_busy_i | input | 1 | JTAG is accessing the bus |
| dbg0_i | input | 1 | Processor 0 is in debug mode |
| dbg1_i | input | 1 | Processor 1 is in debug mode |
| warm_rst0_i | input | 1 | Debugger warm reset of processor 0 |
| warm_rst1_i | input | 1 | Debugger warm reset of processor 1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| wdog_rst_o | output | 1 | One-cycle watchdog reset request |
| reason_o | output | 2 | Recorded cause: bit 1 forced, bit 0 timer |

## Verification
The bench builds the block with CNT_W = 8 and keeps the other parameters at their defaults. With an 8-bit count, every start value from 0 to 255 can be run to expiry with the tick held high. Each run's tick count is compared against the start value, with 0 and 1 both expected to fire on the first tick. Every pairing of the three arming bits with the three pause inputs (64 cases) is swept for a single tick. The scratch words, the undefined offsets, soft-reset retention and warm-reset clearing are covered by targeted sequences.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned N_PAUSE  = 3;
  // word indices (byte address >> 2)
  localparam int unsigned W_CTRL   = 0;
  localparam int unsigned W_LOAD   = 1;
  localparam int unsigned W_REASON = 2;
  localparam int unsigned W_SCR0   = 3;
  // control word bit positions
  localparam int unsigned B_PAUSE  = 24;
  localparam int unsigned B_EN     = 30;
  localparam int unsigned B_TRIG   = 31;

  typedef struct packed {
    logic forced;
    logic timer;
  } cause_t;
endpackage

// File: rtl/wdt_pause.sv
module wdt_pause #(
  parameter int unsigned N_SRC = 3
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] arm_i,
  output logic             paused_o
);
  logic [N_SRC-1:0] gated;
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign gated[g] = src_i[g] & arm_i[g];
  end
  assign paused_o = |gated;
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q <= CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (clear_i)                         cnt_q <= '0;
    else if (load_i)                          cnt_q <= load_val_i;
    else if (run_i && tick_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile import wdt_pkg::*; #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned N_SCR = 8,
  parameter int unsigned AW    = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               fire_i,
  input  logic               expire_i,
  input  logic               warm_clr_i,
  output logic               en_o,
  output logic [N_PAUSE-1:0] arm_o,
  output cause_t             reason_o,
  output logic               load_o,
  output logic               trig_o
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] widx;
  logic          unused_lsb;
  logic          wr_ctrl;
  logic [DW-1:0] scr_q [N_SCR];

  assign widx       = addr_i[AW-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign wr_ctrl    = wr_en_i && (widx == IW'(W_CTRL));
  assign trig_o     = wr_ctrl && wdata_i[B_TRIG];
  assign load_o     = wr_en_i && (widx == IW'(W_LOAD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      arm_o <= '0;
    end else if (wr_ctrl) begin
      en_o  <= wdata_i[B_EN] & ~fire_i;
      arm_o <= wdata_i[B_PAUSE +: N_PAUSE];
    end else if (fire_i) begin
      en_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         reason_o <= '0;
    else if (fire_i)     reason_o <= '{forced: trig_o, timer: expire_i};
    else if (warm_clr_i) reason_o <= '0;
  end

  for (genvar k = 0; k < N_SCR; k++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) scr_q[k] <= '0;
      else if (wr_en_i && widx == IW'(W_SCR0 + k)) scr_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (widx == IW'(W_CTRL)) begin
      rdata_o[CNT_W-1:0]         = cnt_i;
      rdata_o[B_PAUSE +: N_PAUSE] = arm_o;
      rdata_o[B_EN]              = en_o;
    end else if (widx == IW'(W_REASON)) begin
      rdata_o[1:0] = reason_o;
    end
    for (int k = 0; k < N_SCR; k++) begin
      if (widx == IW'(W_SCR0 + k)) rdata_o = scr_q[k];
    end
  end
endmodule

// File: rtl/soft_watchdog.sv
module soft_watchdog import wdt_pkg::*; #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned N_SCR = 8,
  parameter int unsigned AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          jtag_busy_i,
  input  logic          dbg0_i,
  input  logic          dbg1_i,
  input  logic          warm_rst0_i,
  input  logic          warm_rst1_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          wdog_rst_o,
  output logic [1:0]    reason_o
);
  logic               en, paused, run, load, trig, expire, fire, rst_q;
  logic [N_PAUSE-1:0] arm;
  logic [CNT_W-1:0]   cnt;
  cause_t             cause;

  assign run  = en & ~paused;
  assign fire = trig | expire;

  wdt_pause #(.N_SRC(N_PAUSE)) u_pause (
    .src_i    ({dbg1_i, dbg0_i, jtag_busy_i}),
    .arm_i    (arm),
    .paused_o (paused)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (fire),
    .load_i     (load),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .run_i      (run),
    .tick_i     (tick_i),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  wdt_regfile #(.CNT_W(CNT_W), .N_SCR(N_SCR), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cnt_i      (cnt),
    .fire_i     (fire),
    .expire_i   (expire),
    .warm_clr_i (warm_rst0_i | warm_rst1_i),
    .en_o       (en),
    .arm_o      (arm),
    .reason_o   (cause),
    .load_o     (load),
    .trig_o     (trig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= fire;
  end

  assign wdog_rst_o = rst_q;
  assign reason_o   = cause;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned AW    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wdog_rst,
  input logic             en,
  input logic             run,
  input logic             load,
  input logic             fire,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       reason,
  input logic [AW-1:0]    addr,
  input logic [31:0]      rdata
);
  // R7
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst |-> (!en && cnt == '0));
  // R5
  cause_logged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst |-> reason != 2'b00);
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !load && !fire) |=> $stable(cnt));
  // R3
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> cnt <= $past(cnt));
  // R6
  trig_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr[AW-1:2] == '0) |-> !rdata[31]);
endmodule

bind soft_watchdog wdt_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wdog_rst (wdog_rst_o),
  .en       (en),
  .run      (run),
  .load     (load),
  .fire     (fire),
  .cnt      (cnt),
  .reason   (reason_o),
  .addr     (addr_i),
  .rdata    (rdata_o)
);

// File: tb/soft_watchdog_test.sv
module soft_watchdog_test;
  localparam int CW = 8;
  localparam int AW = 6;

  logic clk = 0, rst_ni = 0, tick = 0, jtag = 0, d0 = 0, d1 = 0, w0 = 0, w1 = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          wdog_rst;
  logic [1:0]    reason;
  int n_cmp = 0, n_err = 0;

  always #2 clk = ~clk;

  soft_watchdog #(.CNT_W(CW), .N_SCR(8), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .jtag_busy_i(jtag), .dbg0_i(d0), .dbg1_i(d1),
    .warm_rst0_i(w0), .warm_rst1_i(w1), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .wdog_rst_o(wdog_rst), .reason_o(reason)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; #1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic expire_run(int l, logic [2:0] arm);
    int n = 0;
    logic [31:0] v;
    wr(6'h04, l);
    @(negedge clk); wr_en = 1; addr = 6'h00; wdata = 32'h4000_0000 | (32'(arm) << 24);
    @(negedge clk); wr_en = 0; tick = 1;
    while (n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (wdog_rst) break;
    end
    tick = 0; #1;
    check($sformatf("R5 ticks to expiry load=%0d", l), n, (l == 0) ? 1 : l);
    check("R5 cause timer", 32'(reason), 32'h1);
    rd(6'h00, v);
    check("R7 soft clear keeps arming", v, 32'(arm) << 24);
    @(negedge clk); #1;
    check("R5 single cycle request", 32'(wdog_rst), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1; #1;
    // R1
    check("R1 request low", 32'(wdog_rst), 0);
    check("R1 cause zero", 32'(reason), 0);
    for (int a = 0; a < 64; a += 4) begin
      rd(6'(a), v); check($sformatf("R1 word %h", a), v, 0);
    end
    // R2
    wr(6'h04, 32'hABCD_EF5A);
    rd(6'h00, v); check("R2 load view", v, 32'h5A);
    rd(6'h04, v); check("R2 load reads zero", v, 0);
    // R10
    wr(6'h00, 32'h2000_00FF);
    rd(6'h00, v); check("R10 count view not writable", v, 32'h5A);
    wr(6'h08, 32'h3);
    check("R10 cause not writable", 32'(reason), 0);
    for (int a = 6'h2C; a < 64; a += 4) begin
      rd(6'(a), v); check($sformatf("R10 undefined %h", a), v, 0);
    end
    // R3 disabled hold
    @(negedge clk); tick = 1; @(negedge clk); tick = 0; #1;
    rd(6'h00, v); check("R3 hold while disabled", v, 32'h5A);
    // R3 R4 pause sweep
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 8; s++) begin
        wr(6'h04, 100);
        jtag = s[0]; d0 = s[1]; d1 = s[2];
        wr(6'h00, 32'h4000_0000 | (32'(m) << 24));
        @(negedge clk); tick = 1; @(negedge clk); tick = 0; #1;
        rd(6'h00, v);
        check($sformatf("R4 pause m=%0d s=%0d", m, s), v,
              32'h4000_0000 | (32'(m) << 24) | (((m & s) == 0) ? 99 : 100));
        wr(6'h00, 0);
      end
    end
    jtag = 0; d0 = 0; d1 = 0;
    // R5 R7 exhaustive expiry
    for (int l = 0; l < 256; l++) expire_run(l, 3'(l % 8));
    wr(6'h00, 0);
    // R8
    @(negedge clk); w0 = 1; @(negedge clk); w0 = 0; #1;
    check("R8 warm0 clears cause", 32'(reason), 0);
    // R9 scratch
    for (int k = 0; k < 8; k++) wr(6'(12 + 4 * k), 32'hA5A5_0000 ^ (32'h1111_1111 * k));
    // R6
    wr(6'h04, 32'h40);
    @(negedge clk); wr_en = 1; addr = 6'h00; wdata = 32'hC000_0000;
    @(negedge clk); wr_en = 0; #1;
    check("R6 request on trigger", 32'(wdog_rst), 1);
    check("R6 cause forced", 32'(reason), 2);
    rd(6'h00, v); check("R6 R7 ctrl after trigger", v, 0);
    @(negedge clk); #1;
    check("R6 single cycle request", 32'(wdog_rst), 0);
    for (int k = 0; k < 8; k++) begin
      rd(6'(12 + 4 * k), v);
      check($sformatf("R9 scratch %0d kept", k), v, 32'hA5A5_0000 ^ (32'h1111_1111 * k));
    end
    @(negedge clk); w1 = 1; @(negedge clk); w1 = 0; #1;
    check("R8 warm1 clears cause", 32'(reason), 0);
    // R1 hardware reset clears scratch
    hw_reset(); #1;
    for (int k = 0; k < 8; k++) begin
      rd(6'(12 + 4 * k), v); check($sformatf("R1 scratch %0d cleared", k), v, 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule